// File: doc/BRIEF.md
# DMA Descriptor Address Generator

This block turns a DMA channel descriptor into the source read address and destination write address of the transfer that is due next. A descriptor holds a source end pointer, a destination end pointer and a 32-bit control word. Addresses are derived backwards from the end pointers. The remaining-transfer count in the control word is shifted left by the increment code for that side, and the result is subtracted from the end pointer. An increment code of 3 pins that side to a fixed address.

A `load` pulse captures a descriptor. Each `xfer_done` pulse retires one transfer. The count is decremented, and the updated control word is presented on `ctrl_out`, ready to be written back to descriptor memory. The `last` output marks the final transfer. When that transfer retires, the cycle-control field is cleared, and the channel goes idle until the next load. Bus access and arbitration are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, `ctrl_out`, `src_addr` and `dst_addr` are 0 and `last` is 0.
- R2: A `load` pulse at a clock edge makes `ctrl_out` equal `ctrl_in` after that edge. The address outputs then follow the newly captured end pointers.
- R3: With the source increment code (control bits [27:26]) at 0, 1 or 2, `src_addr` equals the source end pointer minus (count << code). The count is control bits [13:4].
- R4: An increment code of 3 makes the address on that side equal its end pointer, whatever the count.
- R5: `dst_addr` follows the rule of R3 and R4, using the destination end pointer and the destination increment code (control bits [31:30]).
- R6: While the cycle-control field (bits [2:0]) is nonzero and the count is nonzero, an `xfer_done` pulse decrements the count by 1. All other control bits are left unchanged.
- R7: `last` is 1 exactly when the cycle-control field is nonzero and the count is 0.
- R8: An `xfer_done` pulse while `last` is 1 clears bits [2:0] to 000. The count stays 0, all other bits are kept, and `last` falls.
- R9: An `xfer_done` pulse while bits [2:0] are 000 has no effect: `ctrl_out` and both addresses keep their values.
- R10: When `load` and `xfer_done` are both high in the same cycle, the load wins and `ctrl_out` equals `ctrl_in`.
- R11: Address subtraction is modulo 2^ADDR_W. A result below zero wraps without any indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture a new descriptor |
| src_end_in | input | ADDR_W | Source end pointer to capture |
| dst_end_in | input | ADDR_W | Destination end pointer to capture |
| ctrl_in | input | 32 | Control word to capture |
| xfer_done | input | 1 | One transfer has completed |
| src_addr | output | ADDR_W | Current source read address |
| dst_addr | output | ADDR_W | Current destination write address |
| ctrl_out | output | 32 | Updated control word for write-back |
| last | output | 1 | Current transfer is the final one |

## Verification
The assertions check the following on every cycle:
- the one-step count decrement with the other bits preserved;
- the clearing of the cycle-control field on the final completion;
- the idle-channel hold;
- load priority;
- the fixed-address code and the zero-count meaning of `last`.

The arithmetic of the backward address for each increment code, the modulo wrap below zero, and whole count-down sequences with their address stepping are shown only by the bench's directed scenarios. The bench compares these results against values it computes itself.

// File: rtl/dag_pkg.sv
package dag_pkg;
  localparam int CTRL_W   = 32;
  localparam int CNT_LSB  = 4;
  localparam int CNT_W    = 10;
  localparam int CYC_LSB  = 0;
  localparam int CYC_W    = 3;
  localparam int SINC_LSB = 26;
  localparam int DINC_LSB = 30;
  localparam int INC_W    = 2;
  localparam logic [INC_W-1:0] INC_FIXED = 2'd3;

  function automatic logic [CNT_W-1:0] get_count(input logic [CTRL_W-1:0] w);
    return w[CNT_LSB +: CNT_W];
  endfunction

  function automatic logic [CYC_W-1:0] get_cycle(input logic [CTRL_W-1:0] w);
    return w[CYC_LSB +: CYC_W];
  endfunction
endpackage

// File: rtl/dag_addr_calc.sv
module dag_addr_calc #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 10,
  parameter int INC_W  = 2
) (
  input  logic [ADDR_W-1:0] end_ptr,
  input  logic [CNT_W-1:0]  count,
  input  logic [INC_W-1:0]  inc,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [INC_W-1:0] FIXED = {INC_W{1'b1}};

  logic [ADDR_W-1:0] count_ext;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    count_ext = ADDR_W'(count);
    offset    = count_ext << inc;
    if (inc == FIXED) begin
      addr = end_ptr;
    end else begin
      addr = end_ptr - offset;
    end
  end
endmodule

// File: rtl/dag_ctrl_next.sv
module dag_ctrl_next
  import dag_pkg::*;
(
  input  logic [CTRL_W-1:0] ctrl_cur,
  output logic [CTRL_W-1:0] ctrl_nxt,
  output logic              is_last,
  output logic              is_active
);
  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt       = get_count(ctrl_cur);
    is_active = get_cycle(ctrl_cur) != '0;
    is_last   = is_active && (cnt == '0);
    ctrl_nxt  = ctrl_cur;
    if (is_last) begin
      ctrl_nxt[CYC_LSB +: CYC_W] = '0;
    end else if (is_active) begin
      ctrl_nxt[CNT_LSB +: CNT_W] = cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] src_end_in,
  input  logic [ADDR_W-1:0] dst_end_in,
  input  logic [CTRL_W-1:0] ctrl_in,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [CTRL_W-1:0] ctrl_out,
  output logic              last
);
  localparam int NSIDE = 2;

  logic [ADDR_W-1:0] src_end_q, dst_end_q, src_end_d, dst_end_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d, ctrl_step;
  logic              reg_en, step_last, step_active;

  dag_ctrl_next u_next (
    .ctrl_cur  (ctrl_q),
    .ctrl_nxt  (ctrl_step),
    .is_last   (step_last),
    .is_active (step_active)
  );

  // next-state
  always_comb begin
    reg_en    = load | xfer_done;
    src_end_d = src_end_q;
    dst_end_d = dst_end_q;
    ctrl_d    = ctrl_q;
    if (load) begin
      src_end_d = src_end_in;
      dst_end_d = dst_end_in;
      ctrl_d    = ctrl_in;
    end else if (xfer_done) begin
      ctrl_d    = ctrl_step;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_end_q <= '0;
      dst_end_q <= '0;
      ctrl_q    <= '0;
    end else if (reg_en) begin
      src_end_q <= src_end_d;
      dst_end_q <= dst_end_d;
      ctrl_q    <= ctrl_d;
    end
  end

  logic [ADDR_W-1:0] side_end  [NSIDE];
  logic [INC_W-1:0]  side_inc  [NSIDE];
  logic [ADDR_W-1:0] side_addr [NSIDE];

  always_comb begin
    side_end[0] = src_end_q;
    side_end[1] = dst_end_q;
    side_inc[0] = ctrl_q[SINC_LSB +: INC_W];
    side_inc[1] = ctrl_q[DINC_LSB +: INC_W];
  end

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    dag_addr_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_calc (
      .end_ptr (side_end[g]),
      .count   (get_count(ctrl_q)),
      .inc     (side_inc[g]),
      .addr    (side_addr[g])
    );
  end

  assign src_addr = side_addr[0];
  assign dst_addr = side_addr[1];
  assign ctrl_out = ctrl_q;
  assign last     = step_last;
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk
  import dag_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load,
  input logic              xfer_done,
  input logic [CTRL_W-1:0] ctrl_in,
  input logic [CTRL_W-1:0] ctrl_out,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] dst_addr,
  input logic [ADDR_W-1:0] src_end_q,
  input logic              last
);
  logic [CNT_W-1:0] cnt;
  logic [CYC_W-1:0] cyc;
  assign cnt = ctrl_out[CNT_LSB +: CNT_W];
  assign cyc = ctrl_out[CYC_LSB +: CYC_W];

  // R6
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !load && cyc != '0 && cnt != '0) |=>
      (ctrl_out[CNT_LSB +: CNT_W] == $past(cnt) - 1'b1) &&
      (ctrl_out[CTRL_W-1:CNT_LSB+CNT_W] == $past(ctrl_out[CTRL_W-1:CNT_LSB+CNT_W])) &&
      (ctrl_out[CNT_LSB-1:0] == $past(ctrl_out[CNT_LSB-1:0])));

  // R8
  a_r8_final_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !load && last) |=>
      (cyc == '0) && !last && (ctrl_out[CTRL_W-1:CYC_W] == $past(ctrl_out[CTRL_W-1:CYC_W])));

  // R9
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && !load && cyc == '0) |=> $stable(ctrl_out) && $stable(src_addr) && $stable(dst_addr));

  // R10
  a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ctrl_out == $past(ctrl_in));

  // R7
  a_r7_last_zero: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> (cnt == '0) && (cyc != '0));

  // R4
  a_r4_fixed_src: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_out[SINC_LSB +: INC_W] == INC_FIXED) |-> src_addr == src_end_q);
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load      (load),
  .xfer_done (xfer_done),
  .ctrl_in   (ctrl_in),
  .ctrl_out  (ctrl_out),
  .src_addr  (src_addr),
  .dst_addr  (dst_addr),
  .src_end_q (src_end_q),
  .last      (last)
);

// File: tb/dma_addr_gen_test.sv
module dma_addr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] src_end_in = '0, dst_end_in = '0, ctrl_in = '0;
  logic [31:0] src_addr, dst_addr, ctrl_out;
  logic        last;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dma_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .load(load), .src_end_in(src_end_in),
    .dst_end_in(dst_end_in), .ctrl_in(ctrl_in), .xfer_done(xfer_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .ctrl_out(ctrl_out), .last(last)
  );

  function automatic logic [31:0] mk(input logic [1:0] di, input logic [1:0] si,
                                     input logic [9:0] n, input logic [2:0] cy);
    return {di, 2'b10, si, 2'b10, 6'b0, 4'b0010, n, 1'b0, cy};
  endfunction

  function automatic logic [31:0] want(input logic [31:0] e, input logic [9:0] n,
                                       input logic [1:0] inc);
    if (inc == 2'd3) return e;
    return e - (32'(n) * (32'd1 << inc));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    @(negedge clk);
    src_end_in = s; dst_end_in = d; ctrl_in = c; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic do_done();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_out, 32'h0);
    chk("R1 src", src_addr, 32'h0);
    chk("R1 dst", dst_addr, 32'h0);
    chk("R1 last", 32'(last), 32'h0);
  endtask

  task automatic t_modes();
    logic [31:0] c;
    c = mk(2'd1, 2'd0, 10'd5, 3'b110);
    do_load(32'h1000, 32'h2000, c);
    chk("R2 ctrl", ctrl_out, c);
    chk("R3 inc0", src_addr, want(32'h1000, 10'd5, 2'd0));
    chk("R5 inc1", dst_addr, want(32'h2000, 10'd5, 2'd1));
    c = mk(2'd3, 2'd2, 10'd7, 3'b110);
    do_load(32'h1000, 32'h2000, c);
    chk("R3 inc2", src_addr, want(32'h1000, 10'd7, 2'd2));
    chk("R4 dst fixed", dst_addr, 32'h2000);
    c = mk(2'd2, 2'd3, 10'd9, 3'b110);
    do_load(32'h4444, 32'h8000, c);
    chk("R4 src fixed", src_addr, 32'h4444);
    chk("R5 inc2", dst_addr, want(32'h8000, 10'd9, 2'd2));
  endtask

  task automatic t_countdown();
    logic [31:0] c;
    c = mk(2'd2, 2'd1, 10'd2, 3'b110);
    do_load(32'h100, 32'h200, c);
    chk("R7 not last", 32'(last), 32'h0);
    do_done();
    chk("R6 step1", ctrl_out, mk(2'd2, 2'd1, 10'd1, 3'b110));
    chk("R3 advance", src_addr, 32'h100 - 32'd2);
    chk("R5 advance", dst_addr, 32'h200 - 32'd4);
    do_done();
    chk("R6 step2", ctrl_out, mk(2'd2, 2'd1, 10'd0, 3'b110));
    chk("R7 last", 32'(last), 32'h1);
    chk("R3 at end", src_addr, 32'h100);
    do_done();
    chk("R8 cleared", ctrl_out, mk(2'd2, 2'd1, 10'd0, 3'b000));
    chk("R8 last low", 32'(last), 32'h0);
    do_done();
    chk("R9 ctrl hold", ctrl_out, mk(2'd2, 2'd1, 10'd0, 3'b000));
    chk("R9 src hold", src_addr, 32'h100);
    chk("R9 dst hold", dst_addr, 32'h200);
  endtask

  task automatic t_wrap();
    do_load(32'h3, 32'h0, mk(2'd0, 2'd2, 10'd4, 3'b001));
    chk("R11 src wrap", src_addr, 32'hFFFF_FFF3);
    chk("R11 dst wrap", dst_addr, 32'hFFFF_FFFC);
  endtask

  task automatic t_priority();
    logic [31:0] c;
    c = mk(2'd0, 2'd0, 10'd3, 3'b111);
    @(negedge clk);
    src_end_in = 32'h50; dst_end_in = 32'h60; ctrl_in = c;
    load = 1'b1; xfer_done = 1'b1;
    @(negedge clk);
    load = 1'b0; xfer_done = 1'b0;
    chk("R10 load wins", ctrl_out, c);
    chk("R10 src", src_addr, 32'h50 - 32'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_modes();
    t_countdown();
    t_wrap();
    t_priority();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule